// File: doc/BRIEF.md
# UART Sample-Rate Generator

This block derives the sampling rhythm of a serial receiver and transmitter from the core clock. A configuration word written over a simple write strobe sets a 13-bit clock divisor and a 5-bit oversampling setting. From these the block produces a one-cycle sample tick every `divisor` clock cycles. It also produces a one-cycle bit strobe on the last sample tick of every bit period. Bit rate is therefore the input clock divided by the product of samples-per-bit and the divisor.

The same configuration word carries two settings that the shift logic uses: a two-stop-bit select and a both-edge sampling enable. The block passes these through. It refuses the oversampling codes 1 and 2: a write that carries either code updates every other field and keeps the previous oversampling setting. When the oversampling setting lies between 3 and 6 and both-edge sampling is off, the block raises a configuration warning. A divisor of zero silences both pulse outputs. Every configuration write restarts both counters, so that no period is ever built from a mix of old and new settings.

Top module: `baud_tick_gen`

## Requirements
- R1: After reset the stored configuration is all zero. `cfg_rdata_o` reads 0, and `sample_tick_o`, `bit_strobe_o`, `stop_two_o`, `both_edge_o` and `cfg_warn_o` are all low.
- R2: Field layout of the configuration word:
  - divisor in bits 12:0
  - two-stop-bit select in bit 13
  - both-edge enable in bit 17
  - oversampling code in bits 28:24

  A write stores these fields. `cfg_rdata_o` returns them at the same positions from the cycle after the write, with all other bits zero.
- R3: A write whose oversampling code is 1 or 2 leaves the stored oversampling code unchanged and still updates the other fields. The stored code is never 1 or 2.
- R4: While the stored divisor is 0, `sample_tick_o` and `bit_strobe_o` stay low.
- R5: With divisor D ≥ 1 and no further writes, `sample_tick_o` is a one-cycle pulse that is high exactly after the n-th rising edge following the write edge whenever n is a multiple of D.
- R6: Samples per bit S is 16 for oversampling code 0 and code+1 otherwise.
- R7: A configuration write restarts both counters. Both pulses are low in the cycle after the write edge, and counting begins again from zero.
- R8: `bit_strobe_o` is high exactly on every S-th sample tick after a write, that is after edge n where n is a multiple of D·S. It is never high without `sample_tick_o`.
- R9: `cfg_warn_o` is high exactly when the stored oversampling code is 3, 4, 5 or 6 and the stored both-edge enable is 0.
- R10: `stop_two_o` and `both_edge_o` follow the stored bits 13 and 17.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_wdata_i | input | 32 | Configuration word to write |
| cfg_rdata_o | output | 32 | Stored configuration word |
| sample_tick_o | output | 1 | One-cycle pulse per oversample period |
| bit_strobe_o | output | 1 | One-cycle pulse on the last sample of each bit |
| stop_two_o | output | 1 | Two stop bits selected |
| both_edge_o | output | 1 | Both-edge sampling enabled |
| cfg_warn_o | output | 1 | Oversampling setting needs both-edge sampling |

## Verification
The assertions check the following on every cycle:
- the stored oversampling code is never a reserved value, and a reserved write leaves it stable;
- a zero divisor keeps the tick silent;
- a write is followed by a quiet cycle;
- the bit strobe only occurs together with a sample tick;
- ticks with a divisor of two or more are isolated single-cycle pulses.

The exact period of the ticks, the spacing of the strobes for each oversampling code, the 16x meaning of code 0 and the warning decode are shown only by the bench's sweeps. These sweeps cover all 32 oversampling codes with several small divisors and compare against arithmetic expectations.

// File: rtl/baud_pkg.sv
package baud_pkg;
    localparam int REG_W    = 32;
    localparam int DIV_W    = 13;
    localparam int OSR_W    = 5;
    localparam int DIV_LSB  = 0;
    localparam int STOP_POS = 13;
    localparam int EDGE_POS = 17;
    localparam int OSR_LSB  = 24;
    localparam int OSR_DFLT_LAST = 15;   // code 0 means 16 samples
    localparam int WARN_LO  = 3;
    localparam int WARN_HI  = 6;

    typedef struct packed {
        logic [OSR_W-1:0] osr;
        logic             both_edge;
        logic             stop_two;
        logic [DIV_W-1:0] div;
    } cfg_t;

    // index of the final sample inside one bit period
    function automatic logic [OSR_W-1:0] last_sample(input logic [OSR_W-1:0] osr);
        return (osr == '0) ? OSR_W'(OSR_DFLT_LAST) : osr;
    endfunction

    function automatic logic osr_reserved(input logic [OSR_W-1:0] osr);
        return (osr == OSR_W'(1)) || (osr == OSR_W'(2));
    endfunction
endpackage

// File: rtl/baud_cfg_reg.sv
module baud_cfg_reg
    import baud_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             we_i,
    input  logic [REG_W-1:0] wdata_i,
    output cfg_t             cfg_o,
    output logic             warn_o
);
    typedef struct packed {
        cfg_t cfg;
        logic warn;
    } state_t;

    state_t st_d, st_q;
    logic [OSR_W-1:0] osr_in;

    always_comb begin
        st_d   = st_q;
        osr_in = wdata_i[OSR_LSB +: OSR_W];
        if (we_i) begin
            st_d.cfg.div       = wdata_i[DIV_LSB +: DIV_W];
            st_d.cfg.stop_two  = wdata_i[STOP_POS];
            st_d.cfg.both_edge = wdata_i[EDGE_POS];
            if (!osr_reserved(osr_in)) begin
                st_d.cfg.osr = osr_in;
            end
        end
        st_d.warn = (st_d.cfg.osr >= OSR_W'(WARN_LO)) &&
                    (st_d.cfg.osr <= OSR_W'(WARN_HI)) &&
                    !st_d.cfg.both_edge;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cfg_o  = st_q.cfg;
    assign warn_o = st_q.warn;
endmodule

// File: rtl/baud_prescaler.sv
module baud_prescaler
    import baud_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             reload_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             wrap_o,
    output logic             tick_o
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             tick;
    } state_t;

    state_t st_d, st_q;
    logic   wrap;

    always_comb begin
        wrap = !reload_i && (div_i != '0) && (st_q.cnt == div_i - DIV_W'(1));
        st_d = st_q;
        st_d.tick = wrap;
        if (reload_i || (div_i == '0) || wrap) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + DIV_W'(1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign wrap_o = wrap;
    assign tick_o = st_q.tick;
endmodule

// File: rtl/baud_sample_ctr.sv
module baud_sample_ctr
    import baud_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             reload_i,
    input  logic             wrap_i,
    input  logic [OSR_W-1:0] osr_i,
    output logic             strobe_o
);
    typedef struct packed {
        logic [OSR_W-1:0] idx;
        logic             strobe;
    } state_t;

    state_t st_d, st_q;
    logic   at_last;

    always_comb begin
        st_d    = st_q;
        at_last = (st_q.idx == last_sample(osr_i));
        st_d.strobe = 1'b0;
        if (reload_i) begin
            st_d.idx = '0;
        end else if (wrap_i) begin
            st_d.strobe = at_last;
            st_d.idx    = at_last ? '0 : st_q.idx + OSR_W'(1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign strobe_o = st_q.strobe;
endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen
    import baud_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             cfg_we_i,
    input  logic [REG_W-1:0] cfg_wdata_i,
    output logic [REG_W-1:0] cfg_rdata_o,
    output logic             sample_tick_o,
    output logic             bit_strobe_o,
    output logic             stop_two_o,
    output logic             both_edge_o,
    output logic             cfg_warn_o
);
    cfg_t cfg;
    logic wrap;

    baud_cfg_reg u_cfg (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .we_i    (cfg_we_i),
        .wdata_i (cfg_wdata_i),
        .cfg_o   (cfg),
        .warn_o  (cfg_warn_o)
    );

    baud_prescaler u_pre (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .reload_i (cfg_we_i),
        .div_i    (cfg.div),
        .wrap_o   (wrap),
        .tick_o   (sample_tick_o)
    );

    baud_sample_ctr u_smp (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .reload_i (cfg_we_i),
        .wrap_i   (wrap),
        .osr_i    (cfg.osr),
        .strobe_o (bit_strobe_o)
    );

    always_comb begin
        cfg_rdata_o = '0;
        cfg_rdata_o[DIV_LSB +: DIV_W] = cfg.div;
        cfg_rdata_o[STOP_POS]         = cfg.stop_two;
        cfg_rdata_o[EDGE_POS]         = cfg.both_edge;
        cfg_rdata_o[OSR_LSB +: OSR_W] = cfg.osr;
    end

    assign stop_two_o  = cfg.stop_two;
    assign both_edge_o = cfg.both_edge;
endmodule

// File: rtl/baud_tick_gen_chk.sv
module baud_tick_gen_chk
    import baud_pkg::*;
(
    input logic             clk_i,
    input logic             rst_ni,
    input logic             cfg_we_i,
    input logic [REG_W-1:0] cfg_wdata_i,
    input logic [REG_W-1:0] cfg_rdata_o,
    input logic             sample_tick_o,
    input logic             bit_strobe_o
);
    logic [OSR_W-1:0] osr_st, osr_wr;
    logic [DIV_W-1:0] div_st;
    assign osr_st = cfg_rdata_o[OSR_LSB +: OSR_W];
    assign osr_wr = cfg_wdata_i[OSR_LSB +: OSR_W];
    assign div_st = cfg_rdata_o[DIV_LSB +: DIV_W];

    AST_OSR_NEVER_RESERVED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (osr_st != OSR_W'(1)) && (osr_st != OSR_W'(2))); // R3

    AST_OSR_RESERVED_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cfg_we_i && ((osr_wr == OSR_W'(1)) || (osr_wr == OSR_W'(2)))) |=> $stable(osr_st)); // R3

    AST_DIV_ZERO_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (div_st == '0 && !cfg_we_i) |=> !sample_tick_o); // R4

    AST_TICK_ISOLATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sample_tick_o && div_st >= DIV_W'(2) && !cfg_we_i) |=> !sample_tick_o); // R5

    AST_WRITE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cfg_we_i |=> (!sample_tick_o && !bit_strobe_o)); // R7

    AST_STROBE_WITH_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
        bit_strobe_o |-> sample_tick_o); // R8
endmodule

bind baud_tick_gen baud_tick_gen_chk u_chk (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .cfg_we_i      (cfg_we_i),
    .cfg_wdata_i   (cfg_wdata_i),
    .cfg_rdata_o   (cfg_rdata_o),
    .sample_tick_o (sample_tick_o),
    .bit_strobe_o  (bit_strobe_o)
);

// File: tb/baud_tick_gen_tb.sv
`timescale 1ns/1ps
module baud_tick_gen_tb;
    logic        clk = 1'b0;
    logic        rst_ni = 1'b0;
    logic        cfg_we_i = 1'b0;
    logic [31:0] cfg_wdata_i = '0;
    logic [31:0] cfg_rdata_o;
    logic        sample_tick_o, bit_strobe_o, stop_two_o, both_edge_o, cfg_warn_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    baud_tick_gen u_dut (
        .clk_i         (clk),
        .rst_ni        (rst_ni),
        .cfg_we_i      (cfg_we_i),
        .cfg_wdata_i   (cfg_wdata_i),
        .cfg_rdata_o   (cfg_rdata_o),
        .sample_tick_o (sample_tick_o),
        .bit_strobe_o  (bit_strobe_o),
        .stop_two_o    (stop_two_o),
        .both_edge_o   (both_edge_o),
        .cfg_warn_o    (cfg_warn_o)
    );

    task automatic chk(input bit ok, input string req, input int unsigned act, input int unsigned exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // write at the next edge, return just after it (negedge)
    task automatic wr(input logic [31:0] data);
        @(negedge clk);
        cfg_we_i = 1'b1;
        cfg_wdata_i = data;
        @(posedge clk);
        @(negedge clk);
        cfg_we_i = 1'b0;
    endtask

    int unsigned m_osr = 0;

    function automatic logic [31:0] pack(int unsigned dv, bit st, bit be, int unsigned os);
        return (32'(os) << 24) | (32'(be) << 17) | (32'(st) << 13) | 32'(dv);
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(cfg_rdata_o == 0, "R1 rdata", cfg_rdata_o, 0);
        chk({sample_tick_o, bit_strobe_o, stop_two_o, both_edge_o, cfg_warn_o} == 0,
            "R1 outputs", {sample_tick_o, bit_strobe_o, stop_two_o, both_edge_o, cfg_warn_o}, 0);
        rst_ni = 1'b1;
        repeat (2) @(negedge clk);
        chk(cfg_rdata_o == 0 && !sample_tick_o, "R1 after release", cfg_rdata_o, 0);

        // sweep all oversampling codes against small divisors
        for (int os = 0; os < 32; os++) begin
            for (int dv = 1; dv <= 3; dv++) begin
                bit st = dv[0];
                bit be = os[0];
                int unsigned spb;
                bit exp_warn;
                if (os != 1 && os != 2) m_osr = os;
                spb = (m_osr == 0) ? 16 : m_osr + 1;   // R6
                exp_warn = (m_osr >= 3 && m_osr <= 6 && !be);
                wr(pack(dv, st, be, os));
                // R2 R3 readback, R10 pass-through, R9 warning, R7 quiet cycle
                chk(cfg_rdata_o == pack(dv, st, be, m_osr), "R2/R3 readback", cfg_rdata_o, pack(dv, st, be, m_osr));
                chk(stop_two_o == st && both_edge_o == be, "R10 stop/edge", {stop_two_o, both_edge_o}, {st, be});
                chk(cfg_warn_o == exp_warn, "R9 warn", cfg_warn_o, exp_warn);
                chk(!sample_tick_o && !bit_strobe_o, "R7 quiet after write", {sample_tick_o, bit_strobe_o}, 0);
                for (int n = 1; n <= 2 * dv * spb; n++) begin
                    bit et, es;
                    @(posedge clk);
                    @(negedge clk);
                    et = (n % dv) == 0;
                    es = (n % (dv * spb)) == 0;
                    chk(sample_tick_o == et, "R5 tick", sample_tick_o, et);
                    chk(bit_strobe_o == es, "R6/R8 strobe", bit_strobe_o, es);
                end
            end
        end

        // R3 reserved code keeps earlier value (osr 9 then 2)
        wr(pack(4, 0, 1, 9));
        m_osr = 9;
        wr(pack(5, 1, 0, 2));
        chk(cfg_rdata_o == pack(5, 1, 0, 9), "R3 reserved 2 kept", cfg_rdata_o, pack(5, 1, 0, 9));
        wr(pack(5, 0, 0, 1));
        chk(cfg_rdata_o == pack(5, 0, 0, 9), "R3 reserved 1 kept", cfg_rdata_o, pack(5, 0, 0, 9));

        // R7 restart mid-period: divisor 5, rewrite after 3 cycles
        wr(pack(5, 0, 1, 3));
        repeat (3) @(negedge clk);
        wr(pack(5, 0, 1, 3));
        for (int n = 1; n <= 10; n++) begin
            @(posedge clk);
            @(negedge clk);
            chk(sample_tick_o == ((n % 5) == 0), "R7 restart tick", sample_tick_o, (n % 5) == 0);
        end

        // R4 divisor zero silent
        wr(pack(0, 0, 0, 0));
        for (int n = 0; n < 60; n++) begin
            @(negedge clk);
            chk(!sample_tick_o && !bit_strobe_o, "R4 zero divisor", {sample_tick_o, bit_strobe_o}, 0);
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(4 * 150000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule